// File: doc/BRIEF.md
# Edge-Interrupting GPIO Bank Controller

This block controls 32 general-purpose pins through a small word-addressed register bus. Each pin has a direction bit and an output latch. The output latch can be written whole, or changed a few bits at a time by writing a mask to a set address or to a clear address. Software can therefore flip single pins without a read-modify-write sequence.

Every pin level passes through a two-flop synchroniser and then through one more register that holds the previous level. Rising-edge and falling-edge detection are enabled per pin. Each of the two enable masks has its own set and clear addresses, which take write-one masks. An edge that is enabled latches into a status word, and software clears a status bit by writing 1 to it. The status word is split into two 16-pin halves. Each half raises its own interrupt line while any of its bits is set and that half's enable bit is on.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset, every pin is an input (`pin_oe` all zero), `pin_out` is zero, both edge-enable masks, the status word and the bank-enable bits are zero, and `irq_bank` is low.
- R2: The direction register at byte offset 0x10 makes a pin an input when its bit is 1 and an output when its bit is 0. `pin_oe` is the inverse of this register.
- R3: Writing a mask to 0x18 drives the masked bits of `pin_out` high. Writing a whole word to 0x14 loads `pin_out` directly. Zero bits of a mask leave their outputs unchanged.
- R4: Writing a mask to 0x1C drives the masked bits of `pin_out` low and leaves the zero-mask bits unchanged.
- R5: A read of 0x20 returns the synchronised pin levels, whatever the pin direction. A pin change sampled at clock edge k is visible to a read captured at edge k+2 or later, and a read captured at edge k+1 still returns the old level.
- R6: Rising-edge enables are set by a mask written to 0x24 and cleared by a mask written to 0x28. Falling-edge enables are set through 0x2C and cleared through 0x30. An edge whose type is not enabled for that pin sets no status bit.
- R7: An enabled edge (previous level 0 and current level 1 for rising, 1 and 0 for falling) sets the pin's bit in the status word at 0x34. This happens two clock edges after the pin change is first sampled.
- R8: Writing 1 to a status bit at 0x34 clears it. Zero bits of the written mask leave their status bits unchanged. A status bit falls only through such a write.
- R9: When an enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_bank[b]` is high one cycle after status bits [16b+15:16b] hold any 1 while bit b of the bank-enable register at 0x08 is 1. It is low one cycle after that enable bit is 0.
- R11: Edge detection works the same way on pins configured as outputs.
- R12: Read data appears on `bus_rdata` the cycle after a read request and is zero in every other cycle. Reads of 0x18/0x1C return the output latch, reads of 0x24/0x28 the rising mask, reads of 0x2C/0x30 the falling mask, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data or write-one mask |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output latch driven to the pins |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq_bank | output | 2 | Interrupt line per 16-pin bank |

## Verification
The hardest case to reach is a clearing write to a status bit landing in exactly the cycle in which a new edge on the same pin reaches the detector. The bench changes the pin on one falling clock edge. It waits two more falling edges, which lets the level pass both synchroniser flops, and then presents the write-one-to-clear. Both events therefore arrive at the status register on the same rising edge. A second hard case is a read that races a pin change: the bench issues the read in the same cycle as the change and expects the old level back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_BANK_EN  = 6'h08;
  localparam logic [ADDR_W-1:0] A_DIR      = 6'h10;
  localparam logic [ADDR_W-1:0] A_OUT      = 6'h14;
  localparam logic [ADDR_W-1:0] A_OUT_SET  = 6'h18;
  localparam logic [ADDR_W-1:0] A_OUT_CLR  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_LEVEL    = 6'h20;
  localparam logic [ADDR_W-1:0] A_RISE_SET = 6'h24;
  localparam logic [ADDR_W-1:0] A_RISE_CLR = 6'h28;
  localparam logic [ADDR_W-1:0] A_FALL_SET = 6'h2C;
  localparam logic [ADDR_W-1:0] A_FALL_CLR = 6'h30;
  localparam logic [ADDR_W-1:0] A_STATUS   = 6'h34;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl      = sync_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q;
  logic [W-1:0] hit;

  // Per-pin detector; a fresh edge overrides a same-cycle clear.
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      hit[i] = (rise_en[i] & lvl[i] & ~lvl_prev[i]) |
               (fall_en[i] & ~lvl[i] & lvl_prev[i]);
    end

    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (hit[i])
        stat_q[i] <= 1'b1;
      else if (clr_mask[i])
        stat_q[i] <= 1'b0;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W      = 32,
  parameter int BANK_W = 16,
  localparam int NBANK = W / BANK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     stat,
  input  logic [NBANK-1:0] bank_en,
  output logic [NBANK-1:0] irq
);
  logic [NBANK-1:0] irq_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        irq_q[b] <= 1'b0;
      else
        irq_q[b] <= bank_en[b] & (|stat[b*BANK_W +: BANK_W]);
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int W     = 32,
  parameter int NBANK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      stat,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      out,
  output logic [W-1:0]      rise_en,
  output logic [W-1:0]      fall_en,
  output logic [NBANK-1:0]  bank_en,
  output logic [W-1:0]      stat_clr
);
  logic wr;
  logic rd;
  logic [W-1:0] rd_mux;
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, rdata_q;
  logic [NBANK-1:0] ben_q;

  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      ben_q  <= '0;
    end else if (wr) begin
      unique case (bus_addr)
        A_DIR:      dir_q  <= bus_wdata;
        A_OUT:      out_q  <= bus_wdata;
        A_OUT_SET:  out_q  <= out_q | bus_wdata;
        A_OUT_CLR:  out_q  <= out_q & ~bus_wdata;
        A_RISE_SET: rise_q <= rise_q | bus_wdata;
        A_RISE_CLR: rise_q <= rise_q & ~bus_wdata;
        A_FALL_SET: fall_q <= fall_q | bus_wdata;
        A_FALL_CLR: fall_q <= fall_q & ~bus_wdata;
        A_BANK_EN:  ben_q  <= bus_wdata[NBANK-1:0];
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr && bus_addr == A_STATUS) ? bus_wdata : '0;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_BANK_EN:              rd_mux = {{(W-NBANK){1'b0}}, ben_q};
      A_DIR:                  rd_mux = dir_q;
      A_OUT, A_OUT_SET,
      A_OUT_CLR:              rd_mux = out_q;
      A_LEVEL:                rd_mux = lvl;
      A_RISE_SET, A_RISE_CLR: rd_mux = rise_q;
      A_FALL_SET, A_FALL_CLR: rd_mux = fall_q;
      A_STATUS:               rd_mux = stat;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign dir       = dir_q;
  assign out       = out_q;
  assign rise_en   = rise_q;
  assign fall_en   = fall_q;
  assign bank_en   = ben_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int BANK_W = 16,
  localparam int NBANK = NPINS / BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NBANK-1:0]  irq_bank
);
  logic [NPINS-1:0] lvl, lvl_prev;
  logic [NPINS-1:0] dir_q, out_q, rise_en, fall_en, stat_q, stat_clr;
  logic [NBANK-1:0] bank_en;

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pin_raw(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  gpio_regfile #(.W(NPINS), .NBANK(NBANK)) u_regs (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl(lvl), .stat(stat_q),
    .dir(dir_q), .out(out_q), .rise_en(rise_en), .fall_en(fall_en),
    .bank_en(bank_en), .stat_clr(stat_clr)
  );

  gpio_edge_status #(.W(NPINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .lvl_prev(lvl_prev),
    .rise_en(rise_en), .fall_en(fall_en), .clr_mask(stat_clr), .stat(stat_q)
  );

  gpio_bank_irq #(.W(NPINS), .BANK_W(BANK_W)) u_irq (
    .clk(clk), .rst(rst), .stat(stat_q), .bank_en(bank_en), .irq(irq_bank)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NBANK = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NBANK-1:0]  irq_bank,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  rise_en,
  input logic [NPINS-1:0]  fall_en,
  input logic [NBANK-1:0]  bank_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && irq_bank == '0 && stat_q == '0));

  // R3
  set_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_req && bus_we && bus_addr == A_OUT_SET) |->
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_req && bus_we && bus_addr == A_OUT_CLR) |->
      ((pin_out & $past(bus_wdata)) == '0));

  // R7
  status_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & ~$past(stat_q))) |-> $past(|(rise_en | fall_en)));

  // R8
  status_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(stat_q) & ~stat_q)) |-> $past(bus_req && bus_we && bus_addr == A_STATUS));

  // R10
  for (genvar b = 0; b < NBANK; b++) begin : g_b
    bank_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !bank_en[b] |=> !irq_bank[b]);
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_bank(irq_bank), .stat_q(stat_q),
  .rise_en(rise_en), .fall_en(fall_en), .bank_en(bank_en)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [1:0]  irq_bank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_bank(irq_bank)
  );

  // Behavioural reference, advanced once per rising edge
  logic [31:0] m_dir, m_out, m_rise, m_fall, m_stat, m_s1, m_s2, m_prev, m_rdata;
  logic [1:0]  m_en, m_irq;
  logic [31:0] edg;

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_rdata = '0; m_en = '0; m_irq = '0;
    end else begin
      edg = (m_rise & m_s2 & ~m_prev) | (m_fall & ~m_s2 & m_prev);
      for (int b = 0; b < 2; b++)
        m_irq[b] = m_en[b] && (m_stat[b*16 +: 16] != 0);
      m_rdata = '0;
      if (bus_req && !bus_we) begin
        case (bus_addr)
          6'h08: m_rdata = {30'd0, m_en};
          6'h10: m_rdata = m_dir;
          6'h14, 6'h18, 6'h1C: m_rdata = m_out;
          6'h20: m_rdata = m_s2;
          6'h24, 6'h28: m_rdata = m_rise;
          6'h2C, 6'h30: m_rdata = m_fall;
          6'h34: m_rdata = m_stat;
          default: m_rdata = '0;
        endcase
      end
      if (bus_req && bus_we) begin
        case (bus_addr)
          6'h08: m_en = bus_wdata[1:0];
          6'h10: m_dir = bus_wdata;
          6'h14: m_out = bus_wdata;
          6'h18: m_out = m_out | bus_wdata;
          6'h1C: m_out = m_out & ~bus_wdata;
          6'h24: m_rise = m_rise | bus_wdata;
          6'h28: m_rise = m_rise & ~bus_wdata;
          6'h2C: m_fall = m_fall | bus_wdata;
          6'h30: m_fall = m_fall & ~bus_wdata;
          6'h34: m_stat = m_stat & ~bus_wdata;
          default: ;
        endcase
      end
      m_stat = m_stat | edg;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2 pin_oe", pin_oe, ~m_dir);
      chk("R3 or R4 pin_out", pin_out, m_out);
      chk("R10 irq", {30'd0, irq_bank}, {30'd0, m_irq});
      chk({cur_req, " rdata"}, bus_rdata, m_rdata);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 irq", {30'd0, irq_bank}, 32'h0);
    rd(A_DIR, 32'hFFFF_FFFF, "R1 dir");
    rd(A_STATUS, 32'h0, "R1 status");

    cur_req = "R2";
    wr(A_DIR, 32'hFFFF_0000);
    chk("R2 oe", pin_oe, 32'h0000_FFFF);
    rd(A_DIR, 32'hFFFF_0000, "R2 dir");

    cur_req = "R3";
    wr(A_OUT_SET, 32'h0000_00F5);
    chk("R3 set", pin_out, 32'h0000_00F5);
    wr(A_OUT_SET, 32'h0000_0100);
    chk("R3 keep", pin_out, 32'h0000_01F5);
    cur_req = "R4";
    wr(A_OUT_CLR, 32'h0000_0005);
    chk("R4 clr", pin_out, 32'h0000_01F0);
    cur_req = "R12";
    rd(A_OUT_CLR, 32'h0000_01F0, "R12 clr alias");
    wr(A_OUT, 32'h1234_5678);
    chk("R3 direct", pin_out, 32'h1234_5678);
    rd(A_OUT_SET, 32'h1234_5678, "R12 set alias");
    rd(6'h3C, 32'h0, "R12 unmapped");

    cur_req = "R5";
    @(negedge clk); pin_in = 32'hA5A5_0000; bus_req = 1; bus_we = 0; bus_addr = A_LEVEL;
    @(negedge clk); bus_req = 0;
    chk("R5 stale", bus_rdata, 32'h0);
    idle(2);
    rd(A_LEVEL, 32'hA5A5_0000, "R5 level");

    cur_req = "R6";
    pin_in = '0;
    idle(4);
    wr(A_RISE_SET, 32'h0010_0008);
    wr(A_FALL_SET, 32'h0010_0010);
    wr(A_BANK_EN, 32'h3);
    rd(A_RISE_CLR, 32'h0010_0008, "R12 rise alias");
    rd(A_FALL_CLR, 32'h0010_0010, "R12 fall alias");
    @(negedge clk) pin_in[4] = 1'b1;
    idle(4);
    rd(A_STATUS, 32'h0, "R6 disabled type");

    cur_req = "R7";
    @(negedge clk) pin_in[3] = 1'b1;
    idle(3);
    rd(A_STATUS, 32'h0000_0008, "R7 rise");
    chk("R10 bank0", {30'd0, irq_bank}, 32'h1);
    @(negedge clk) pin_in[4] = 1'b0;
    idle(3);
    rd(A_STATUS, 32'h0000_0018, "R7 fall");

    cur_req = "R8";
    wr(A_STATUS, 32'h0000_0008);
    rd(A_STATUS, 32'h0000_0010, "R8 partial clr");
    wr(A_STATUS, 32'h0000_0010);
    rd(A_STATUS, 32'h0, "R8 all clr");
    idle(1);
    chk("R10 low", {30'd0, irq_bank}, 32'h0);

    cur_req = "R6";
    wr(A_RISE_CLR, 32'h0000_0008);
    @(negedge clk) pin_in[3] = 1'b0;
    idle(1);
    @(negedge clk) pin_in[3] = 1'b1;
    idle(3);
    rd(A_STATUS, 32'h0, "R6 rise cleared");

    cur_req = "R9";
    @(negedge clk) pin_in[20] = 1'b1;
    idle(3);
    rd(A_STATUS, 32'h0010_0000, "R9 setup");
    chk("R10 bank1", {30'd0, irq_bank}, 32'h2);
    @(negedge clk) pin_in[20] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = A_STATUS; bus_wdata = 32'h0010_0000;
    @(negedge clk); bus_req = 0; bus_we = 0;
    rd(A_STATUS, 32'h0010_0000, "R9 edge wins");

    cur_req = "R10";
    wr(A_BANK_EN, 32'h1);
    idle(1);
    chk("R10 gated", {30'd0, irq_bank}, 32'h0);
    wr(A_STATUS, 32'h0010_0000);
    wr(A_BANK_EN, 32'h3);

    cur_req = "R11";
    wr(A_DIR, 32'hFFFF_FFF7);
    wr(A_RISE_SET, 32'h0000_0008);
    @(negedge clk) pin_in[3] = 1'b0;
    idle(1);
    @(negedge clk) pin_in[3] = 1'b1;
    idle(3);
    rd(A_STATUS, 32'h0000_0008, "R11 output pin edge");

    for (int k = 0; k < 40; k++) begin
      @(negedge clk) pin_in = pin_in ^ (32'h0011_0019 & {32{k[0]}});
      if (k % 5 == 0) wr(A_STATUS, 32'hFFFF_FFFF);
    end
    idle(4);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule